// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block pairs an 8-bit free-running event counter with an 8-bit watchdog counter. One power-of-two divider sits between them, and a single control bit decides which of the two counters the divider serves. The counter that does not own the divider counts its own events directly, at 1:1.

The event counter takes one of two sources: an internal instruction-cycle tick input, or an external pin. The pin passes through a two-stage synchroniser and an edge detector, and the active edge can be selected. The watchdog advances on a separate enable input, and a clear input restarts it. When the watchdog counter wraps, it emits a one-cycle timeout pulse.

An 8-bit control word and the counter value can be read and written through a small single-address-bit register port. The event counter keeps a sticky flag that records each wrap from all ones to zero.

Top module: `tw_top`

## Requirements
- R1: After reset, the control word reads 0xFF, the counter reads 0x00, and both the overflow flag and the timeout output are low.
- R2: Address 0 holds the control word and address 1 holds the counter. Reads are combinational, and a write takes effect on the next clock edge. The control fields are: bit 5 = source select, bit 4 = edge select, bit 3 = divider owner, and bits 2:0 = rate. Bits 7 and 6 are stored and read back but change nothing.
- R3: When the owner bit is 0, the counter advances once every 2^(rate+1) source events, which gives 2 for rate 0 and 256 for rate 7.
- R4: When the owner bit is 1, the counter advances on every source event.
- R5: With source select at 1, source events are edges of the synchronised external pin, and the tick input is ignored. With source select at 0, source events are tick-input cycles, and the pin is ignored. Edge select 0 counts rising edges, and edge select 1 counts falling edges.
- R6: The overflow flag sets when the counter steps from 0xFF to 0x00. It stays set until reset or until a write to the counter, which clears it.
- R7: The watchdog emits a timeout after 256 of its own counted events. When the owner bit is 1, each counted event is 2^rate enable cycles. When the owner bit is 0, each enable cycle is one counted event.
- R8: A clear-watchdog pulse zeroes both the watchdog counter and the divider count.
- R9: Any write to the control word, and any write to the counter, zeroes the divider count.
- R10: The timeout output is high for exactly one cycle per wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal instruction-cycle tick |
| ext_i | input | 1 | External count pin, asynchronous |
| wdt_en_i | input | 1 | Watchdog base enable |
| wdt_clr_i | input | 1 | Clear watchdog and divider |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control, 1 = counter |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| cnt_o | output | 8 | Counter value |
| ovf_o | output | 1 | Sticky counter overflow flag |
| wdt_to_o | output | 1 | One-cycle watchdog timeout |

## Verification
The assertions assume that a source event lasts one cycle per event and that the external pin stays at each level for several clocks, so that every edge survives the synchroniser. The divider-spacing check assumes that no clear arrives in the cycle the divider fires. The bench keeps to these assumptions: it pulses tick and enable inputs only as whole cycles, holds the pin for five clocks at each level, and drives every input one time unit after a rising edge.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic             spare_hi;
    logic             spare_lo;
    logic             src_ext;
    logic             fall_edge;
    logic             pre_to_wdt;
    logic [RATE_W-1:0] rate;
  } tw_ctrl_t;

  localparam tw_ctrl_t CTRL_RST = '1;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic fall_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = fall_i ? (!sync_q[STAGES-1] && prev_q)
                          : (sync_q[STAGES-1] && !prev_q);

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (!pulse_o || (fall_i != $past(fall_i)))); // R5
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int unsigned RATE_W = 3,
  localparam int unsigned PW = 2 ** RATE_W,
  localparam int unsigned SW = $clog2(PW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          in_i,
  input  logic [SW-1:0] shift_i,
  output logic          out_o
);
  logic [PW-1:0] cnt_q;
  logic [PW:0]   mask_w;
  logic [PW-1:0] mask;

  assign mask_w = ((PW+1)'(1) << shift_i) - (PW+1)'(1);
  assign mask   = mask_w[PW-1:0];
  assign out_o  = in_i && !clr_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (in_i)  cnt_q <= cnt_q + PW'(1);
  end

  AST_PRE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o && shift_i != '0 && !clr_i) |=> !out_o || clr_i || $past(shift_i) != shift_i); // R3
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (wr_i) begin
      cnt_o <= wdata_i;
      ovf_o <= 1'b0;
    end else if (inc_i) begin
      cnt_o <= cnt_o + W'(1);
      if (&cnt_o) ovf_o <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !wr_i) |=> ovf_o); // R6
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && inc_i && (&cnt_o)) |=> (cnt_o == '0 && ovf_o)); // R6
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int unsigned W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic to_o
);
  logic [W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      to_o   <= 1'b0;
    end else if (clr_i) begin
      base_q <= '0;
      to_o   <= 1'b0;
    end else begin
      to_o <= inc_i && (&base_q);
      if (inc_i) base_q <= base_q + W'(1);
    end
  end

  AST_WDT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_o |=> !to_o); // R10
  AST_WDT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!to_o && base_q == '0)); // R8
endmodule

// File: rtl/tw_top.sv
module tw_top
  import tw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW = 2 ** RATE_W,
  localparam int unsigned SW = $clog2(PW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ext_i,
  input  logic              wdt_en_i,
  input  logic              wdt_clr_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ovf_o,
  output logic              wdt_to_o
);
  tw_ctrl_t ctrl_q;
  logic     ctrl_wr, cnt_wr;
  logic     ext_evt, src_evt, pre_in, pre_out, pre_clr;
  logic     tmr_inc, wdt_inc;
  logic [SW-1:0] shift;

  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);
  assign cnt_wr  = wr_i && (addr_i == ADDR_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= tw_ctrl_t'(wdata_i);
  end

  assign rdata_o = (addr_i == ADDR_CNT) ? cnt_o : DATA_W'(ctrl_q);

  tw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ext_i, .fall_i(ctrl_q.fall_edge), .pulse_o(ext_evt)
  );

  assign src_evt = ctrl_q.src_ext ? ext_evt : tick_i;

  // timer owner divides one step further than watchdog owner
  assign shift   = ctrl_q.pre_to_wdt ? SW'(ctrl_q.rate) : SW'(ctrl_q.rate) + SW'(1);
  assign pre_in  = ctrl_q.pre_to_wdt ? wdt_en_i : src_evt;
  assign pre_clr = ctrl_wr || cnt_wr || wdt_clr_i;

  tw_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(pre_clr), .in_i(pre_in), .shift_i(shift), .out_o(pre_out)
  );

  assign tmr_inc = ctrl_q.pre_to_wdt ? src_evt : pre_out;
  assign wdt_inc = ctrl_q.pre_to_wdt ? pre_out : wdt_en_i;

  tw_timer #(.W(DATA_W)) u_tmr (
    .clk_i, .rst_ni, .wr_i(cnt_wr), .wdata_i, .inc_i(tmr_inc), .cnt_o, .ovf_o
  );

  tw_watchdog #(.W(DATA_W)) u_wdt (
    .clk_i, .rst_ni, .clr_i(wdt_clr_i), .inc_i(wdt_inc), .to_o(wdt_to_o)
  );

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q)); // R2
  AST_TMR_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.pre_to_wdt && src_evt && !cnt_wr) |=> cnt_o == DATA_W'($past(cnt_o) + 1'b1)); // R4
  AST_TMR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.src_ext && !ext_evt && !cnt_wr && !ctrl_wr) |=> $stable(cnt_o)); // R5
endmodule

// File: tb/tb_tw_top.sv
module tb_tw_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, ext = 0, wen = 0, wclr = 0, wr = 0, addr = 0;
  logic [7:0] wdata = 0, rdata, cnt;
  logic ovf, to;
  int checks = 0, fails = 0, to_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tw_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_i(ext), .wdt_en_i(wen),
    .wdt_clr_i(wclr), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cnt_o(cnt), .ovf_o(ovf), .wdt_to_o(to)
  );

  always @(negedge clk) if (rst_n && to) to_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    @(posedge clk); #1 wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    @(posedge clk); #1 addr = a; #1 d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1 tick = 1; end
    @(posedge clk); #1 tick = 0;
  endtask

  task automatic wticks(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1 wen = 1; end
    @(posedge clk); #1 wen = 0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic wdt_clear();
    @(posedge clk); #1 wclr = 1;
    @(posedge clk); #1 wclr = 0;
  endtask

  task automatic pin(logic v);
    @(posedge clk); #1 ext = v;
    repeat (5) @(posedge clk);
    #1;
  endtask

  localparam int NV = 8;
  localparam logic [7:0] V_CTRL [NV] = '{8'h08, 8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08, 8'h06};
  localparam int         V_N    [NV] = '{10, 10, 10, 20, 50, 600, 300, 300};
  localparam logic [7:0] V_EXP  [NV] = '{10, 5, 2, 2, 3, 2, 44, 2};

  initial begin
    logic [7:0] d;
    int base;
    #20 rst_n = 1;
    @(posedge clk); #1;
    rd_reg(0, d); chk("R1 ctrl", d, 8'hFF);
    chk("R1 cnt", cnt, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 to", to, 0);

    // vector table: R3 divided ratios, R4 direct counting
    for (int v = 0; v < NV; v++) begin
      wr_reg(0, V_CTRL[v]);
      wr_reg(1, 0);
      ticks(V_N[v]);
      rd_reg(1, d);
      chk(V_CTRL[v][3] ? "R4 vec" : "R3 vec", d, V_EXP[v]);
    end

    // R2 spare bits stored, no effect
    wr_reg(0, 8'hC8); rd_reg(0, d); chk("R2 readback", d, 8'hC8);
    wr_reg(1, 0); ticks(4); rd_reg(1, d); chk("R2 spare no effect", d, 4);
    wr_reg(1, 8'h5A); rd_reg(1, d); chk("R2 cnt write", d, 8'h5A);

    // R6 overflow
    wr_reg(0, 8'h08); wr_reg(1, 8'hFE);
    ticks(1); chk("R6 pre-wrap cnt", cnt, 8'hFF); chk("R6 pre-wrap flag", ovf, 0);
    ticks(1); chk("R6 wrap cnt", cnt, 0); chk("R6 wrap flag", ovf, 1);
    ticks(1); chk("R6 sticky", ovf, 1);
    wr_reg(1, 8'h05); chk("R6 clear by write", ovf, 0); chk("R6 write value", cnt, 5);

    // R5 external source
    wr_reg(0, 8'h28); wr_reg(1, 0);
    pin(1); chk("R5 rising counted", cnt, 1);
    pin(0); chk("R5 rising ignores fall", cnt, 1);
    ticks(5); chk("R5 tick ignored on ext", cnt, 1);
    wr_reg(0, 8'h38); wr_reg(1, 0);
    pin(1); chk("R5 falling ignores rise", cnt, 0);
    pin(0); chk("R5 falling counted", cnt, 1);
    wr_reg(0, 8'h08); wr_reg(1, 0);
    pin(1); pin(0); chk("R5 pin ignored on tick", cnt, 0);

    // R9 divider clear on writes
    wr_reg(0, 8'h01); wr_reg(1, 0);
    ticks(3); wr_reg(0, 8'h01); ticks(3); rd_reg(1, d); chk("R9 ctrl write clears", d, 0);
    ticks(1); rd_reg(1, d); chk("R9 after clear", d, 1);
    wr_reg(1, 0); ticks(3); wr_reg(1, 0); ticks(3); rd_reg(1, d); chk("R9 cnt write clears", d, 0);

    // R7 watchdog unprescaled, R10 single pulse
    wr_reg(0, 8'h00); wdt_clear();
    base = to_seen; wticks(255); chk("R7 no early timeout", to_seen - base, 0);
    wticks(1); chk("R10 one pulse", to_seen - base, 1); chk("R10 pulse ended", to, 0);
    // R7 watchdog prescaled /2
    wr_reg(0, 8'h09); wdt_clear();
    base = to_seen; wticks(511); chk("R7 div2 early", to_seen - base, 0);
    wticks(1); chk("R7 div2 timeout", to_seen - base, 1);
    // R7 watchdog /1 through owned divider
    wr_reg(0, 8'h08); wdt_clear();
    base = to_seen; wticks(256); chk("R7 div1 timeout", to_seen - base, 1);
    // R8 clear restarts watchdog and divider
    wdt_clear(); base = to_seen;
    wticks(200); wdt_clear(); wticks(200); chk("R8 clear base", to_seen - base, 0);
    wr_reg(0, 8'h09); wdt_clear(); base = to_seen;
    wticks(1); wdt_clear(); wticks(511); chk("R8 clear divider", to_seen - base, 0);
    wticks(1); chk("R8 after clear", to_seen - base, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule